// File: doc/BRIEF.md
# Two-Phase Multiplexed-Address Supercell Memory Controller

This block sits between a host and a small two-dimensional storage array whose cells are supercells of `WORD_W` bits, arranged as `2**ROW_BITS` rows by `2**COL_BITS` columns. The host hands over one request at a time: a flat supercell index, a direction flag and, for a write, one data word. The controller splits the index into a row and a column. It drives both onto one narrow shared address bus, one after the other. The row goes first, with the row strobe held high. The column follows, with the column strobe held high. The whole supercell then moves in one parallel beat.

The array is included and is behavioural but synthesizable. While the row strobe is high, it copies the whole selected row into an internal row buffer. While the column strobe is high, it reads from or updates one entry of that buffer. In the cycle after the column phase, the buffer is written back into the row, and the response is presented to the host.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the host must hold its fields stable until then. `req_ready` stays low from the taking of a request until the cycle after its response, so the host is back-pressured for the full sequence. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and `rsp_rdata` is valid only during that pulse.

Top module: `dc_dram_ctrl`

## Requirements
- R1: After reset `req_ready` is high, `dram_ras`, `dram_cas` and `rsp_valid` are low, and every supercell reads back as zero.
- R2: `req_ready` is low from the edge that takes a request until the response cycle has passed. A `req_valid` presented while `req_ready` is low is not taken and changes no stored data.
- R3: Starting in the cycle after a request is taken, `dram_ras` is high for exactly `STROBE_CYC` cycles. Meanwhile `dram_addr` carries the row, which is the upper `ROW_BITS` bits of `req_index`, zero-extended.
- R4: The column phase follows the row phase at once. `dram_cas` is high for exactly `STROBE_CYC` cycles while `dram_addr` carries the column, which is the lower `COL_BITS` bits of `req_index`. `dram_ras` and `dram_cas` are never high together.
- R5: `rsp_valid` is high for exactly one cycle, the cycle right after the column phase. That cycle is `2*STROBE_CYC+1` cycles after the accepting edge.
- R6: A read (`req_write` = 0) returns in `rsp_rdata` the word currently stored in the addressed supercell.
- R7: A write (`req_write` = 1) stores `req_wdata` in the addressed supercell. Later reads return it, and every other supercell, including those in the same row, keeps its value.
- R8: The response to a write carries the written word in `rsp_rdata`.
- R9: `dram_addr` is zero whenever neither strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | ROW_BITS+COL_BITS | Flat supercell index, row in the upper bits |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | WORD_W | Read data, or the written word for a write |
| dram_addr | output | max(ROW_BITS,COL_BITS) | Shared row/column address bus |
| dram_ras | output | 1 | Row strobe |
| dram_cas | output | 1 | Column strobe |

## Verification
Each result has a fixed due cycle, counted from the edge that takes a request. The row strobe and row address are due in the following `STROBE_CYC` cycles. The column strobe and column address are due in the next `STROBE_CYC` cycles. The response, with its data, is due exactly `2*STROBE_CYC+1` cycles after the accepting edge, and `req_ready` returns one cycle after that.

The bench keeps a phase counter and a word-per-supercell model that advance on the same edges as the design. It compares every output at the falling edge of every cycle, so a strobe or pulse one cycle early or late is caught where it happens. Requests that arrive while the controller is busy are deliberately offered with different data, and the model's contents show that they were not taken.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [1:0] {
    DC_IDLE = 2'd0,
    DC_ROW  = 2'd1,
    DC_COL  = 2'd2,
    DC_DONE = 2'd3
  } dc_state_e;
endpackage

// File: rtl/dc_index_split.sv
module dc_index_split #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2
) (
  input  logic [ROW_BITS+COL_BITS-1:0] index_i,
  output logic [ROW_BITS-1:0]          row_o,
  output logic [COL_BITS-1:0]          col_o
);
  // Row in the upper bits, column in the lower bits: index = row*C + col.
  assign row_o = index_i[ROW_BITS+COL_BITS-1:COL_BITS];
  assign col_o = index_i[COL_BITS-1:0];
endmodule

// File: rtl/dc_sequencer.sv
module dc_sequencer
  import dc_pkg::*;
#(
  parameter int STROBE_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic ras_o,
  output logic cas_o,
  output logic done_o
);
  localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  dc_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_beat;

  assign last_beat   = (cnt_q == CNT_LAST);
  assign req_ready_o = (state_q == DC_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign ras_o       = (state_q == DC_ROW);
  assign cas_o       = (state_q == DC_COL);
  assign done_o      = (state_q == DC_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DC_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        DC_IDLE: begin
          cnt_q <= '0;
          if (req_valid_i) state_q <= DC_ROW;
        end
        DC_ROW: begin
          if (last_beat) begin
            state_q <= DC_COL;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        DC_COL: begin
          if (last_beat) begin
            state_q <= DC_DONE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= DC_IDLE;
      endcase
    end
  end

  // R4: strobes are mutually exclusive
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_o && cas_o));
  // R4: the column phase is entered only straight from the row phase
  assert_cas_after_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_o) |-> $past(ras_o));
  // R2: a taken request drops ready on the next cycle
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !req_ready_o);
  // R5: the response is a single-cycle pulse that follows the column phase
  assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_rsp_after_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(cas_o));
endmodule

// File: rtl/dc_array.sv
module dc_array #(
  parameter int ROW_BITS = 2,
  parameter int COL_BITS = 2,
  parameter int WORD_W   = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_i,
  input  logic              cas_i,
  input  logic              restore_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int ROWS = 1 << ROW_BITS;
  localparam int COLS = 1 << COL_BITS;

  logic [WORD_W-1:0]   cells_q  [ROWS][COLS];
  logic [WORD_W-1:0]   rowbuf_q [COLS];
  logic [ROW_BITS-1:0] open_row_q;
  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;

  assign row_sel = addr_i[ROW_BITS-1:0];
  assign col_sel = addr_i[COL_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells_q[r][c] <= '0;
      for (int c = 0; c < COLS; c++)
        rowbuf_q[c] <= '0;
      open_row_q <= '0;
      rdata_o    <= '0;
    end else begin
      if (ras_i) begin
        open_row_q <= row_sel;
        for (int c = 0; c < COLS; c++)
          rowbuf_q[c] <= cells_q[row_sel][c];
      end else if (cas_i) begin
        if (wr_i) begin
          rowbuf_q[col_sel] <= wdata_i;
          rdata_o           <= wdata_i;
        end else begin
          rdata_o <= rowbuf_q[col_sel];
        end
      end else if (restore_i) begin
        for (int c = 0; c < COLS; c++)
          cells_q[open_row_q][c] <= rowbuf_q[c];
      end
    end
  end

  // R3: the open row follows the address seen during the row strobe
  assert_row_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ras_i |=> open_row_q == $past(row_sel));
  // R8: a write beat reflects the written word on the read port
  assert_write_echo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_i && wr_i) |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/dc_dram_ctrl.sv
module dc_dram_ctrl #(
  parameter int ROW_BITS   = 2,
  parameter int COL_BITS   = 2,
  parameter int WORD_W     = 8,
  parameter int STROBE_CYC = 1,
  localparam int IDX_W     = ROW_BITS + COL_BITS,
  localparam int ADDR_W    = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_ras,
  output logic              dram_cas
);
  logic                accept;
  logic                done;
  logic [ROW_BITS-1:0] row_in, row_q;
  logic [COL_BITS-1:0] col_in, col_q;
  logic                wr_q;
  logic [WORD_W-1:0]   wdata_q;

  dc_index_split #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_split (
    .index_i (req_index),
    .row_o   (row_in),
    .col_o   (col_in)
  );

  dc_sequencer #(.STROBE_CYC(STROBE_CYC)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .req_ready_o (req_ready),
    .accept_o    (accept),
    .ras_o       (dram_ras),
    .cas_o       (dram_cas),
    .done_o      (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= row_in;
      col_q   <= col_in;
      wr_q    <= req_write;
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    if (dram_ras)      dram_addr = ADDR_W'(row_q);
    else if (dram_cas) dram_addr = ADDR_W'(col_q);
    else               dram_addr = '0;
  end

  dc_array #(
    .ROW_BITS (ROW_BITS),
    .COL_BITS (COL_BITS),
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_i     (dram_ras),
    .cas_i     (dram_cas),
    .restore_i (done),
    .addr_i    (dram_addr),
    .wr_i      (wr_q),
    .wdata_i   (wdata_q),
    .rdata_o   (rsp_rdata)
  );

  assign rsp_valid = done;

  // R9: the shared bus is quiet outside both strobe phases
  assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_ras && !dram_cas) |-> dram_addr == '0);
  // R2: no request is taken while a response is being presented
  assert_no_take_in_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
endmodule

// File: tb/dc_dram_ctrl_tb.sv
module dc_dram_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS   = 2;
  localparam int COL_BITS   = 2;
  localparam int WORD_W     = 8;
  localparam int STROBE_CYC = 2;
  localparam int IDX_W      = ROW_BITS + COL_BITS;
  localparam int ADDR_W     = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS;
  localparam int NCELL      = 1 << IDX_W;
  localparam int LAST_PH    = 2 * STROBE_CYC + 1;
  localparam int WATCHDOG   = 50000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [IDX_W-1:0]  req_index = '0;
  logic [WORD_W-1:0] req_wdata = '0;
  logic              rsp_valid;
  logic [WORD_W-1:0] rsp_rdata;
  logic [ADDR_W-1:0] dram_addr;
  logic              dram_ras;
  logic              dram_cas;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;
  string rd_tag = "R6";

  // behavioural reference
  int m_phase = 0;
  int m_mem [NCELL];
  int m_row = 0, m_col = 0, m_exp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_dram_ctrl #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS),
    .WORD_W(WORD_W), .STROBE_CYC(STROBE_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_addr(dram_addr), .dram_ras(dram_ras), .dram_cas(dram_cas)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      for (int i = 0; i < NCELL; i++) m_mem[i] = 0;
    end else if (m_phase == 0) begin
      if (req_valid) begin
        m_phase = 1;
        m_row = int'(req_index) / (1 << COL_BITS);
        m_col = int'(req_index) % (1 << COL_BITS);
        if (req_write) begin
          m_mem[req_index] = int'(req_wdata);
          m_exp = int'(req_wdata);
        end else begin
          m_exp = m_mem[req_index];
        end
      end
    end else if (m_phase == LAST_PH) begin
      m_phase = 0;
    end else begin
      m_phase = m_phase + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_ras, e_cas;
    int e_addr;
    e_ras  = (m_phase >= 1) && (m_phase <= STROBE_CYC);
    e_cas  = (m_phase > STROBE_CYC) && (m_phase <= 2 * STROBE_CYC);
    e_addr = e_ras ? m_row : (e_cas ? m_col : 0);
    check(rst_n ? "R2 ready" : "R1 ready", int'(req_ready), int'(m_phase == 0));
    check(rst_n ? "R3 ras" : "R1 ras", int'(dram_ras), int'(e_ras));
    check("R4 cas", int'(dram_cas), int'(e_cas));
    check(e_ras ? "R3 addr" : (e_cas ? "R4 addr" : "R9 addr"), int'(dram_addr), e_addr);
    check(rst_n ? "R5 rsp_valid" : "R1 rsp_valid", int'(rsp_valid), int'(m_phase == LAST_PH));
    if (m_phase == LAST_PH) check(rd_tag, int'(rsp_rdata), m_exp);
  endtask

  task automatic tick();
    @(negedge clk);
    cycles++;
    compare_all();
  endtask

  // one access; busy cycles offer a junk request that must not be taken (R2)
  task automatic access(input bit wr, input int idx, input int data, input bit junk);
    req_valid = 1'b1;
    req_write = wr;
    req_index = IDX_W'(idx);
    req_wdata = WORD_W'(data);
    do tick(); while (m_phase == 0);
    while (m_phase != 0) begin
      req_valid = junk && (m_phase < LAST_PH);
      req_write = 1'b1;
      req_index = IDX_W'(idx ^ 1);
      req_wdata = 8'hFF;
      tick();
    end
    req_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    if (!finished && cycles > WATCHDOG) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    rd_tag = "R1 cleared";
    for (int i = 0; i < NCELL; i++) access(1'b0, i, 0, 1'b0);
    // R7 R8: writes across rows and columns, back-to-back, with junk offers
    rd_tag = "R8 write echo";
    for (int i = 0; i < NCELL; i++) access(1'b1, i, 8'h10 + i * 7, i[0]);
    // R6 R7 R2: readback shows stored data and no junk landed
    rd_tag = "R6 R7 readback";
    for (int i = NCELL - 1; i >= 0; i--) access(1'b0, i, 0, 1'b1);
    // R7: overwrite one cell of row 2, neighbours in the row keep values
    rd_tag = "R8 write echo";
    access(1'b1, 9, 8'hA5, 1'b0);
    repeat (2) tick();
    rd_tag = "R7 same row";
    for (int c = 0; c < (1 << COL_BITS); c++) access(1'b0, 8 + c, 0, 1'b0);
    // boundary: highest index, all-ones data
    rd_tag = "R8 write echo";
    access(1'b1, NCELL - 1, 8'hFF, 1'b1);
    rd_tag = "R6 corner";
    access(1'b0, NCELL - 1, 0, 1'b0);
    access(1'b0, 0, 0, 1'b0);
    repeat (3) tick();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule